// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Core

This block holds the synchronous control logic of a pipelined burst SRAM, built around a small internal array. By default the array has 64 words of 36 bits, split into four byte lanes of 9 bits each. Every control input is sampled on the rising clock edge. The inputs are:

- two competing address strobes, one for a processor and one for a controller;
- an advance input;
- three chip selects;
- a global write, a byte-write gate and one write select per lane.

From these the core decides on each edge whether to load a new address, step the 2-bit burst counter or stay deselected. It then performs at most one access on that edge.

Read data leaves through a register and appears one edge after the access. The data bus has separate input and output ports and an output-drive flag. That flag follows an asynchronous, active-low output enable. The data path is pin-level: every edge takes exactly one access, so there is no valid/ready handshake and no back-pressure. A caller that pauses simply holds the advance input high, and the same location is accessed again.

Top module: `bsram_core`

## Requirements
- R1: When the controller strobe is sampled low and the chip selects are active (`cs1_n`=0, `cs2`=1, `cs3_n`=0), the core loads `addr`. For a read, the word at that address is shown on `d_out` after the next rising edge.
- R2: When both strobes are low in one cycle, only the processor strobe counts. A processor-strobe load is always a read: the global write, byte-write gate and lane selects are ignored in that cycle.
- R3: The processor strobe has no effect while `cs1_n` is high, and the burst in progress continues. The controller strobe is not gated by `cs1_n`. A controller load with `cs1_n` high deselects the core.
- R4: `cs2` and `cs3_n` are looked at only on a cycle that loads an address. Changing them during a burst has no effect.
- R5: A load with inactive chip selects puts the core in the deselected state. In that state there are no reads and no writes, `adv_n` is ignored and `d_oe` stays low, until the next load with active selects.
- R6: With no strobe active, `adv_n` low moves the access to the next address. Only the two low address bits count up, wrapping 3 to 0; the upper bits are fixed for the burst. With `adv_n` high, the same address is accessed again.
- R7: `gw_n` low writes all four lanes, whatever `bwe_n` and `lane_sel_n` hold.
- R8: Without a global write, `bwe_n` low makes the cycle a write. Lane i (bits 9i+8..9i) is written only when `lane_sel_n[i]` is low. With `bwe_n` and `gw_n` both high, the cycle is a read.
- R9: `d_oe` is high only while `oe_n` is low and the last edge performed a read; it follows `oe_n` without waiting for a clock. After a write edge, and in the first cycle of a load that leaves the deselected state, `d_oe` is low.
- R10: A write stores `d_in` on the same edge that samples the write controls. It goes to the current burst address, or to `addr` on a controller-strobe load.
- R11: While `rst_n` is low, and after it is released, the core is deselected with `d_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External address |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | First chip select, active low |
| cs2 | input | 1 | Second chip select, active high |
| cs3_n | input | 1 | Third chip select, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write gate, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_in | input | LANES*LANE_W | Write data |
| d_out | output | LANES*LANE_W | Registered read data |
| d_oe | output | 1 | High when the data bus is driven |

## Verification
The array is first filled by controller-strobe global writes, so every later read exposes the address it came from. Bursts that start at low-bit values 0 and 3 show the wrap and that the upper bits stay fixed. Repeat cycles (advance high) separate holding the address from stepping it. Byte writes with mixed lane selects, and a global write with the byte gate idle, tell lane decoding apart from global override. Cycles with both strobes low, or with the processor strobe under a high `cs1_n`, and writes attempted while deselected, show the priority and gating rules at the data port.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/bsram_addr_ctl.sv
module bsram_addr_ctl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  output logic              load,
  output logic              sel_ok,
  output logic              proc_load,
  output logic              acc_valid,
  output logic              active_q,
  output logic [ADDR_W-1:0] cur_q,
  output logic [ADDR_W-1:0] eff_addr
);
  import bsram_pkg::*;
  localparam int HI_W = ADDR_W - BURST_W;

  logic [BURST_W-1:0] cnt_next;

  // processor strobe is gated by the first select; controller strobe is not
  assign proc_load = !proc_stb_n && !cs1_n;
  assign load      = proc_load || !ctrl_stb_n;
  assign sel_ok    = !cs1_n && cs2 && !cs3_n;
  assign cnt_next  = cur_q[BURST_W-1:0] + {{(BURST_W-1){1'b0}}, !adv_n};

  always_comb begin
    if (load) begin
      acc_valid = sel_ok;
      eff_addr  = addr;
    end else begin
      acc_valid = active_q;
      eff_addr  = {cur_q[ADDR_W-1 -: HI_W], cnt_next};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cur_q    <= '0;
    end else if (load) begin
      active_q <= sel_ok;
      if (sel_ok) cur_q <= addr;
    end else if (active_q) begin
      cur_q <= eff_addr;
    end
  end
endmodule

// File: rtl/bsram_wr_dec.sv
module bsram_wr_dec #(
  parameter int LANES = 4
) (
  input  logic                 acc_valid,
  input  logic                 proc_load,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [LANES-1:0]     lane_sel_n,
  output bsram_pkg::acc_kind_e kind,
  output logic [LANES-1:0]     lane_we
);
  import bsram_pkg::*;

  always_comb begin
    lane_we = '0;
    if (!acc_valid) begin
      kind = ACC_NONE;
    end else if (!proc_load && (!gw_n || !bwe_n)) begin
      kind    = ACC_WRITE;
      lane_we = !gw_n ? {LANES{1'b1}} : ~lane_sel_n;
    end else begin
      kind = ACC_READ;
    end
  end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       eff_addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    rd_en,
  input  logic [LANES*LANE_W-1:0] d_in,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[eff_addr] <= d_in[g*LANE_W +: LANE_W];
      if (rd_en)      rd_q          <= mem[eff_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= rd_en;
  end
endmodule

// File: rtl/bsram_core.sv
module bsram_core #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_stb_n,
  input  logic                    ctrl_stb_n,
  input  logic                    adv_n,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] d_in,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic                    d_oe
);
  import bsram_pkg::*;

  logic              load, sel_ok, proc_load, acc_valid, active_q, rd_vld;
  logic [ADDR_W-1:0] cur_q, eff_addr;
  logic [LANES-1:0]  lane_we;
  acc_kind_e         kind;

  bsram_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .load(load), .sel_ok(sel_ok), .proc_load(proc_load),
    .acc_valid(acc_valid), .active_q(active_q), .cur_q(cur_q),
    .eff_addr(eff_addr)
  );

  bsram_wr_dec #(.LANES(LANES)) u_wdec (
    .acc_valid(acc_valid), .proc_load(proc_load), .gw_n(gw_n),
    .bwe_n(bwe_n), .lane_sel_n(lane_sel_n), .kind(kind), .lane_we(lane_we)
  );

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .eff_addr(eff_addr), .lane_we(lane_we),
    .rd_en(kind == ACC_READ), .d_in(d_in), .rd_data(d_out), .rd_vld(rd_vld)
  );

  // asynchronous output enable, qualified by a read on the last edge
  assign d_oe = !oe_n && rd_vld;
endmodule

// File: rtl/bsram_core_chk.sv
module bsram_core_chk #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n,
  input logic             d_oe,
  input logic             adv_n,
  input logic             load,
  input logic             sel_ok,
  input logic             proc_load,
  input logic             active_q,
  input logic [AW-1:0]    cur_q,
  input logic [LANES-1:0] lane_we
);
  a_r9_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !d_oe);

  a_r9_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |=> !d_oe);

  a_r5_desel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !load) |-> (lane_we == '0));

  a_r5_desel_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sel_ok) |=> !d_oe);

  a_r2_proc_is_read: assert property (@(posedge clk) disable iff (!rst_n)
    proc_load |-> (lane_we == '0));

  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && active_q) |=> $stable(cur_q[AW-1:2]));

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && active_q && !adv_n && cur_q[1:0] == 2'b11) |=> (cur_q[1:0] == 2'b00));
endmodule

bind bsram_core bsram_core_chk #(.AW(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .d_oe(d_oe), .adv_n(adv_n),
  .load(load), .sel_ok(sel_ok), .proc_load(proc_load),
  .active_q(active_q), .cur_q(cur_q), .lane_we(lane_we)
);

// File: tb/bsram_core_tb.sv
`timescale 1ns/1ps
module bsram_core_tb;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic proc_stb_n = 1, ctrl_stb_n = 1, adv_n = 1;
  logic cs1_n = 0, cs2 = 1, cs3_n = 0, gw_n = 1, bwe_n = 1, oe_n = 0;
  logic [NL-1:0] lane_sel_n = '1;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] d_out;
  logic d_oe;

  int nchk = 0, nerr = 0;

  // reference model state
  logic [DW-1:0] mdl [64];
  bit            m_act = 0, m_vld = 0;
  logic [AW-1:0] m_cur = '0;
  logic [DW-1:0] m_dat = '0;

  always #2 clk = ~clk;

  bsram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .gw_n(gw_n), .bwe_n(bwe_n), .lane_sel_n(lane_sel_n),
    .oe_n(oe_n), .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 36'h1_0203) ^ 36'hA_5C3C_96E1;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  task automatic check_out(input string tag);
    bit eo;
    eo = !oe_n && m_vld;
    nchk++;
    if (d_oe !== eo || (eo && d_out !== m_dat)) begin
      nerr++;
      $display("FAIL %s: d_oe=%b d_out=%h expected d_oe=%b d_out=%h",
               tag, d_oe, d_out, eo, m_dat);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic ps = 1, input logic cs = 1, input logic av = 1,
                     input logic c1 = 0, input logic c2 = 1, input logic c3 = 0,
                     input logic g = 1, input logic b = 1,
                     input logic [NL-1:0] bs = '1, input logic oe = 0,
                     input logic [AW-1:0] a = '0, input logic [DW-1:0] di = '0,
                     input string tag = "R1");
    bit pl, ld, sel, acc, wr;
    logic [AW-1:0] eff;
    proc_stb_n = ps; ctrl_stb_n = cs; adv_n = av; cs1_n = c1; cs2 = c2;
    cs3_n = c3; gw_n = g; bwe_n = b; lane_sel_n = bs; oe_n = oe;
    addr = a; d_in = di;
    @(posedge clk);
    pl  = !ps && !c1;
    ld  = pl || !cs;
    sel = !c1 && c2 && !c3;
    eff = m_cur;
    acc = 0;
    if (ld) begin
      m_act = sel;
      acc   = sel;
      eff   = a;
    end else if (m_act) begin
      acc = 1;
      eff = {m_cur[AW-1:2], 2'(m_cur[1:0] + (av ? 2'd0 : 2'd1))};
    end
    if (acc) m_cur = eff;
    wr = acc && !pl && (!g || !b);
    if (wr) begin
      for (int l = 0; l < NL; l++)
        if (!g || !bs[l]) mdl[eff][l*LW +: LW] = di[l*LW +: LW];
    end
    m_vld = acc && !wr;
    if (m_vld) m_dat = mdl[eff];
    @(negedge clk);
    check_out(tag);
  endtask

  initial begin
    #(4ns * 200000);
    nerr++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check_out("R11");
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R11");

    // R7 / R10: fill every word with controller-strobe global writes
    for (int a = 0; a < 64; a++)
      cyc(.cs(0), .g(0), .a(AW'(a)), .di(pat(a)), .tag("R7"));

    // R1: controller load then read
    cyc(.cs(0), .a(6'd10), .tag("R1"));
    cyc(.tag("R6"));                         // adv high: same word again
    cyc(.ps(0), .a(6'd12), .tag("R1"));      // processor load read

    // R6: burst from low bits 3 wraps inside upper bits
    cyc(.cs(0), .a(6'd7), .tag("R6"));
    for (int k = 0; k < 5; k++) cyc(.av(0), .tag("R6"));

    // R10: burst write at the current burst address, then read back
    cyc(.cs(0), .g(0), .a(6'd20), .di(36'h1_1111_1111), .tag("R10"));
    cyc(.av(0), .g(0), .di(36'h2_2222_2222), .tag("R10"));
    cyc(.cs(0), .a(6'd20), .tag("R10"));
    cyc(.av(0), .tag("R10"));

    // R8: byte writes on lanes 0 and 2, then no write with gate idle
    cyc(.cs(0), .b(0), .bs(4'b1010), .a(6'd30), .di(36'hF_FFFF_FFFF), .tag("R8"));
    cyc(.b(1), .bs(4'b0000), .di(36'h0), .tag("R8"));
    cyc(.cs(0), .a(6'd30), .tag("R8"));
    // R7: global write overrides idle byte gate and deselected lanes
    cyc(.cs(0), .g(0), .b(1), .bs(4'b1111), .a(6'd31), .di(36'h3_3333_3333), .tag("R7"));
    cyc(.cs(0), .a(6'd31), .tag("R7"));

    // R2: both strobes low with write controls: read only, no write
    cyc(.ps(0), .cs(0), .g(0), .b(0), .bs(4'b0000), .a(6'd40), .di(36'h0), .tag("R2"));
    cyc(.cs(0), .a(6'd40), .tag("R2"));

    // R4: selects changed during a burst have no effect
    cyc(.cs(0), .a(6'd44), .tag("R4"));
    cyc(.av(0), .c2(0), .c3(1), .tag("R4"));
    cyc(.av(0), .c2(0), .c3(1), .tag("R4"));

    // R3: processor strobe under cs1_n high is ignored; burst goes on
    cyc(.ps(0), .c1(1), .av(0), .a(6'd2), .tag("R3"));
    // R3 / R5: controller strobe with cs1_n high deselects
    cyc(.cs(0), .c1(1), .a(6'd50), .tag("R3"));
    cyc(.av(0), .tag("R5"));
    cyc(.g(0), .di(36'h0), .tag("R5"));      // write attempt while deselected
    cyc(.cs(0), .c2(0), .a(6'd51), .tag("R5"));
    // R9: leaving deselect, first cycle tri-stated, then data
    cyc(.cs(0), .a(6'd47), .tag("R9"));
    cyc(.av(0), .tag("R5"));                 // word 44 burst/word 47: unchanged by write attempt
    cyc(.cs(0), .a(6'd45), .tag("R5"));

    // R9: output enable acts without a clock
    #1 oe_n = 1'b1;
    #0.5;
    nchk++;
    if (d_oe !== 1'b0) begin
      nerr++;
      $display("FAIL R9: d_oe=%b expected d_oe=0 with oe_n high", d_oe);
    end
    oe_n = 1'b0;
    #0.5;
    check_out("R9");
    cyc(.oe(1), .tag("R9"));
    // R9: write edge leaves bus undriven
    cyc(.cs(0), .g(0), .a(6'd60), .di(36'h4_4444_4444), .tag("R9"));
    cyc(.cs(0), .a(6'd60), .tag("R10"));

    finish_run();
  end
endmodule